// File: doc/BRIEF.md
# USB Power Delivery Transmit Arbiter

This block decides which of three transmit sources reaches the PD physical-layer transmitter: acknowledge replies made locally for received messages, messages queued by the protocol layer, and hard reset. It issues single-cycle start commands tagged with a source code, then watches the transmitter's completion status.

A protocol message is not complete when the transmitter reports it sent. The block then waits a bounded time for an acknowledge that carries the message's ID. If that acknowledge does not arrive, or the transmitter reports a failure, the block retransmits. The number of retransmissions depends on the specification revision of the pending message. A received message cancels a pending or in-flight protocol message and raises a discarded pulse. A hard-reset request overrides all other activity at any time.

The surrounding logic supplies request strobes, the pending message's ID and revision, and receiver and transmitter events. It takes back start commands and success, failed and discarded status pulses.

Top module: `pd_tx_arbiter`

## Requirements
- R1: A cycle with `hr_req_i` high is followed, on the next cycle, by `start_o` high with `start_src_o` = 2 (hard reset), whatever the current activity. A pending protocol-message request is dropped, and no status pulse is produced on that cycle.
- R2: Once in hard reset, the block ignores transmitter status. On `hr_done_i` or `hr_fail_i` it returns to idle and drops every pending acknowledge and message request, including requests that arrived during the hard reset, so no further start follows.
- R3: When an acknowledge request and a message request are both pending in idle, the acknowledge is started first (`start_src_o` = 0). The message (`start_src_o` = 1) starts only after the acknowledge's transmitter status.
- R4: If a received-message event (`rx_msg_i`) arrives while a protocol message is pending but not yet started, the request is dropped. The block gives one `disc_o` pulse one cycle later and never starts that message.
- R5: A pending protocol message is not started while `rx_busy_i` is high. It starts after `rx_busy_i` falls.
- R6: After `phy_ok_i` for a protocol message, `ok_o` pulses one cycle after an `rx_ack_i` whose `rx_ack_id_i` equals the `msg_id_i` sampled at the first start. An acknowledge with any other ID has no effect.
- R7: The acknowledge wait lasts exactly `CYC_PER_US*ACK_WAIT_US` cycles, counted from the cycle after `phy_ok_i`. On expiry the block retransmits if it is below the retry limit; otherwise it pulses `fail_o`.
- R8: The retry limit is `RETRY_REV3` (default 2) when `msg_rev3_i` = 1 and `RETRY_REV2` (default 3) when it is 0. This gives limit+1 starts in total. At the limit, a `phy_fail_i` produces `fail_o` and a `phy_disc_i` produces `disc_o`.
- R9: A transmitter failure or discard that follows a received-message event during the same message transmission ends with `disc_o` and no retransmission.
- R10: A received-message event while waiting for the acknowledge ends the wait with `disc_o` and no retransmission.
- R11: An acknowledge transmission ends on any of `phy_ok_i`, `phy_fail_i` or `phy_disc_i` and produces no status pulse.
- R12: The retry count restarts at zero for every new transmission, so a message that follows one that used up its retries gets its full number of retries.
- R13: After reset all outputs are low. `ok_o`, `fail_o` and `disc_o` are single-cycle, mutually exclusive pulses, and `start_src_o` is never 3 while `start_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ack_req_i | input | 1 | Strobe: an acknowledge reply is ready to send |
| msg_req_i | input | 1 | Strobe: a protocol message is ready to send |
| hr_req_i | input | 1 | Strobe: send hard reset now |
| msg_rev3_i | input | 1 | Pending message uses revision 3.0 (1) or 2.0 (0) |
| msg_id_i | input | ID_W | ID of the pending protocol message |
| rx_busy_i | input | 1 | A reception is in progress |
| rx_msg_i | input | 1 | Pulse: a non-acknowledge message was received |
| rx_ack_i | input | 1 | Pulse: an acknowledge was received |
| rx_ack_id_i | input | ID_W | ID carried by the received acknowledge |
| phy_ok_i | input | 1 | Pulse: transmitter sent the frame |
| phy_fail_i | input | 1 | Pulse: transmitter aborted or underran |
| phy_disc_i | input | 1 | Pulse: transmitter discarded the frame |
| hr_done_i | input | 1 | Pulse: hard reset sent |
| hr_fail_i | input | 1 | Pulse: hard reset discarded |
| start_o | output | 1 | Start command to the transmitter |
| start_src_o | output | 2 | Source of the start: 0 acknowledge, 1 message, 2 hard reset |
| ok_o | output | 1 | Pulse: message acknowledged |
| fail_o | output | 1 | Pulse: message failed |
| disc_o | output | 1 | Pulse: message discarded |

## Verification
The bench targets the orderings that are easy to get wrong. These are: an acknowledge and a message pending together, a received message arriving before, during and after the message's transmission, and a hard reset arriving while a message is in flight with an acknowledge queued. A design that favours the message would show source 1 first. A design that ignores the sticky reception would retransmit instead of discarding. A design that keeps queued requests across hard reset would start a transmission after the reset completes.

The retry limit is exercised for both revisions and for both terminal causes. An off-by-one in the limit shows up as a wrong start count, and a missing count reset shows up as a single start on the next message. The acknowledge wait is timed to the exact cycle, and an acknowledge with the wrong ID is sent first to catch an ID compare that is missing.

// File: rtl/pd_tx_pkg.sv
package pd_tx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_ACK  = 3'd1,
      ST_MSG  = 3'd2,
      ST_WAIT = 3'd3,
      ST_HRST = 3'd4
   } pd_tx_state_e;

   localparam logic [1:0] SRC_ACK  = 2'd0;
   localparam logic [1:0] SRC_MSG  = 2'd1;
   localparam logic [1:0] SRC_HRST = 2'd2;

endpackage

// File: rtl/pd_tx_ack_timer.sv
module pd_tx_ack_timer #(
   parameter int CYC_PER_US  = 125,
   parameter int ACK_WAIT_US = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic expired_o
);
   localparam int TOTAL = CYC_PER_US * ACK_WAIT_US;
   localparam int CW    = (TOTAL > 1) ? $clog2(TOTAL) : 1;
   localparam logic [CW-1:0] LAST = CW'(TOTAL - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (run_i)  cnt_q <= (cnt_q == LAST) ? cnt_q : cnt_q + 1'b1;
      else             cnt_q <= '0;
   end

   assign expired_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/pd_tx_retry.sv
module pd_tx_retry #(
   parameter int RETRY_REV3 = 2,
   parameter int RETRY_REV2 = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   input  logic rev3_i,
   input  logic bump_i,
   input  logic clr_i,
   output logic below_o
);
   localparam int MAXR = (RETRY_REV3 > RETRY_REV2) ? RETRY_REV3 : RETRY_REV2;
   localparam int CW   = $clog2(MAXR + 1);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] lim_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         lim_q <= '0;
      end else if (load_i) begin
         cnt_q <= '0;
         lim_q <= rev3_i ? CW'(RETRY_REV3) : CW'(RETRY_REV2);
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (bump_i) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign below_o = cnt_q < lim_q;
endmodule

// File: rtl/pd_tx_arbiter.sv
module pd_tx_arbiter
   import pd_tx_pkg::*;
#(
   parameter int CYC_PER_US  = 125,
   parameter int ACK_WAIT_US = 1000,
   parameter int RETRY_REV3  = 2,
   parameter int RETRY_REV2  = 3,
   parameter int ID_W        = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ack_req_i,
   input  logic            msg_req_i,
   input  logic            hr_req_i,
   input  logic            msg_rev3_i,
   input  logic [ID_W-1:0] msg_id_i,
   input  logic            rx_busy_i,
   input  logic            rx_msg_i,
   input  logic            rx_ack_i,
   input  logic [ID_W-1:0] rx_ack_id_i,
   input  logic            phy_ok_i,
   input  logic            phy_fail_i,
   input  logic            phy_disc_i,
   input  logic            hr_done_i,
   input  logic            hr_fail_i,
   output logic            start_o,
   output logic [1:0]      start_src_o,
   output logic            ok_o,
   output logic            fail_o,
   output logic            disc_o
);

   // elaboration-time parameter checks
   if (CYC_PER_US < 1) begin : g_bad_cyc
      initial $fatal(1, "CYC_PER_US must be at least 1");
   end
   if (ACK_WAIT_US < 1) begin : g_bad_wait
      initial $fatal(1, "ACK_WAIT_US must be at least 1");
   end
   if (RETRY_REV3 < 1 || RETRY_REV2 < 1) begin : g_bad_retry
      initial $fatal(1, "retry limits must be at least 1");
   end
   if (ID_W < 1) begin : g_bad_id
      initial $fatal(1, "ID_W must be at least 1");
   end

   pd_tx_state_e    state_q, st_n;
   logic            ack_pend_q, msg_pend_q, rx_flag_q;
   logic [ID_W-1:0] id_q;
   logic            start_n, ok_n, fail_n, disc_n;
   logic [1:0]      src_n;
   logic            ack_clr, msg_clr, rx_clr, all_clr, id_load;
   logic            rt_load, rt_bump, rt_clr, below;
   logic            expired;
   logic            rx_evt, phy_any;

   pd_tx_ack_timer #(
      .CYC_PER_US  (CYC_PER_US),
      .ACK_WAIT_US (ACK_WAIT_US)
   ) i_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (state_q == ST_WAIT),
      .expired_o (expired)
   );

   pd_tx_retry #(
      .RETRY_REV3 (RETRY_REV3),
      .RETRY_REV2 (RETRY_REV2)
   ) i_retry (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (rt_load),
      .rev3_i  (msg_rev3_i),
      .bump_i  (rt_bump),
      .clr_i   (rt_clr),
      .below_o (below)
   );

   assign rx_evt  = rx_flag_q | rx_msg_i;
   assign phy_any = phy_ok_i | phy_fail_i | phy_disc_i;

   always_comb begin
      st_n    = state_q;
      start_n = 1'b0;
      src_n   = start_src_o;
      ok_n    = 1'b0;
      fail_n  = 1'b0;
      disc_n  = 1'b0;
      ack_clr = 1'b0;
      msg_clr = 1'b0;
      rx_clr  = 1'b0;
      all_clr = 1'b0;
      id_load = 1'b0;
      rt_load = 1'b0;
      rt_bump = 1'b0;
      rt_clr  = 1'b0;

      unique case (state_q)
         ST_IDLE: begin
            if (ack_pend_q) begin
               st_n    = ST_ACK;
               ack_clr = 1'b1;
               start_n = 1'b1;
               src_n   = SRC_ACK;
               rt_clr  = 1'b1;
            end else if (msg_pend_q) begin
               if (rx_evt) begin
                  msg_clr = 1'b1;
                  disc_n  = 1'b1;
                  rx_clr  = 1'b1;
               end else if (!rx_busy_i) begin
                  st_n    = ST_MSG;
                  msg_clr = 1'b1;
                  start_n = 1'b1;
                  src_n   = SRC_MSG;
                  rt_load = 1'b1;
                  id_load = 1'b1;
                  rx_clr  = 1'b1;
               end
            end else begin
               rx_clr = 1'b1;
            end
         end
         ST_ACK: begin
            if (phy_any) st_n = ST_IDLE;
         end
         ST_MSG: begin
            if (phy_ok_i) begin
               st_n = ST_WAIT;
            end else if (phy_fail_i || phy_disc_i) begin
               if (below) begin
                  if (rx_evt) begin
                     st_n   = ST_IDLE;
                     disc_n = 1'b1;
                     rx_clr = 1'b1;
                  end else begin
                     start_n = 1'b1;
                     src_n   = SRC_MSG;
                     rt_bump = 1'b1;
                  end
               end else begin
                  st_n   = ST_IDLE;
                  fail_n = phy_fail_i;
                  disc_n = !phy_fail_i;
               end
            end
         end
         ST_WAIT: begin
            if (rx_ack_i && (rx_ack_id_i == id_q)) begin
               st_n = ST_IDLE;
               ok_n = 1'b1;
            end else if (expired) begin
               if (below) begin
                  st_n    = ST_MSG;
                  start_n = 1'b1;
                  src_n   = SRC_MSG;
                  rt_bump = 1'b1;
               end else begin
                  st_n   = ST_IDLE;
                  fail_n = 1'b1;
               end
            end else if (rx_evt) begin
               st_n   = ST_IDLE;
               disc_n = 1'b1;
               rx_clr = 1'b1;
            end
         end
         ST_HRST: begin
            if (hr_done_i || hr_fail_i) begin
               st_n    = ST_IDLE;
               all_clr = 1'b1;
               rt_clr  = 1'b1;
            end
         end
         default: st_n = ST_IDLE;
      endcase

      // hard reset overrides every decision above
      if (hr_req_i) begin
         st_n    = ST_HRST;
         start_n = 1'b1;
         src_n   = SRC_HRST;
         ok_n    = 1'b0;
         fail_n  = 1'b0;
         disc_n  = 1'b0;
         ack_clr = 1'b0;
         msg_clr = 1'b1;
         all_clr = 1'b0;
         id_load = 1'b0;
         rt_load = 1'b0;
         rt_bump = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         ack_pend_q  <= 1'b0;
         msg_pend_q  <= 1'b0;
         rx_flag_q   <= 1'b0;
         id_q        <= '0;
         start_o     <= 1'b0;
         start_src_o <= SRC_ACK;
         ok_o        <= 1'b0;
         fail_o      <= 1'b0;
         disc_o      <= 1'b0;
      end else begin
         state_q     <= st_n;
         ack_pend_q  <= all_clr ? 1'b0 : (ack_req_i | (ack_pend_q & ~ack_clr));
         msg_pend_q  <= (all_clr | hr_req_i) ? 1'b0
                                             : (msg_req_i | (msg_pend_q & ~msg_clr));
         rx_flag_q   <= all_clr ? 1'b0 : (rx_evt & ~rx_clr);
         if (id_load) id_q <= msg_id_i;
         start_o     <= start_n;
         start_src_o <= src_n;
         ok_o        <= ok_n;
         fail_o      <= fail_n;
         disc_o      <= disc_n;
      end
   end

endmodule

// File: rtl/pd_tx_arbiter_chk.sv
module pd_tx_arbiter_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       hr_req_i,
   input logic       rx_ack_i,
   input logic       start_o,
   input logic [1:0] start_src_o,
   input logic       ok_o,
   input logic       fail_o,
   input logic       disc_o
);
   AST_HR_START: assert property (@(posedge clk) disable iff (!rst_n)
      hr_req_i |=> (start_o && start_src_o == 2'd2));                          // R1
   AST_HR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (start_o && start_src_o == 2'd2) |-> !(ok_o || fail_o || disc_o));      // R1
   AST_OK_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      ok_o |-> $past(rx_ack_i));                                               // R6
   AST_ONE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ok_o, fail_o, disc_o}));                                       // R13
   AST_OK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      ok_o |=> !ok_o);                                                         // R13
   AST_FAIL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      fail_o |=> !fail_o);                                                     // R13
   AST_SRC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |-> (start_src_o != 2'd3));                                      // R13
endmodule

bind pd_tx_arbiter pd_tx_arbiter_chk i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .hr_req_i    (hr_req_i),
   .rx_ack_i    (rx_ack_i),
   .start_o     (start_o),
   .start_src_o (start_src_o),
   .ok_o        (ok_o),
   .fail_o      (fail_o),
   .disc_o      (disc_o)
);

// File: tb/test_pd_tx_arbiter.sv
`timescale 1ns/1ps
module test_pd_tx_arbiter;
   localparam int CPU  = 2;
   localparam int WUS  = 5;
   localparam int TOUT = CPU * WUS;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ack_req_i = 0, msg_req_i = 0, hr_req_i = 0, msg_rev3_i = 0;
   logic [2:0] msg_id_i = '0, rx_ack_id_i = '0;
   logic rx_busy_i = 0, rx_msg_i = 0, rx_ack_i = 0;
   logic phy_ok_i = 0, phy_fail_i = 0, phy_disc_i = 0, hr_done_i = 0, hr_fail_i = 0;
   logic start_o, ok_o, fail_o, disc_o;
   logic [1:0] start_src_o;

   int n_vec = 0, n_bad = 0;
   int cyc = 0, n_start = 0, n_ok = 0, n_fl = 0, n_dc = 0;
   int last_src = -1, last_start_cyc = 0;

   always #4 clk = ~clk;

   pd_tx_arbiter #(.CYC_PER_US(CPU), .ACK_WAIT_US(WUS), .RETRY_REV3(2),
                   .RETRY_REV2(3), .ID_W(3)) i_pd_tx_arbiter (
      .clk(clk), .rst_n(rst_n), .ack_req_i(ack_req_i), .msg_req_i(msg_req_i),
      .hr_req_i(hr_req_i), .msg_rev3_i(msg_rev3_i), .msg_id_i(msg_id_i),
      .rx_busy_i(rx_busy_i), .rx_msg_i(rx_msg_i), .rx_ack_i(rx_ack_i),
      .rx_ack_id_i(rx_ack_id_i), .phy_ok_i(phy_ok_i), .phy_fail_i(phy_fail_i),
      .phy_disc_i(phy_disc_i), .hr_done_i(hr_done_i), .hr_fail_i(hr_fail_i),
      .start_o(start_o), .start_src_o(start_src_o), .ok_o(ok_o),
      .fail_o(fail_o), .disc_o(disc_o));

   // output monitor, 2 ns after each rising edge
   always begin
      @(posedge clk);
      #2;
      cyc++;
      if (start_o) begin
         n_start++;
         last_src = int'(start_src_o);
         last_start_cyc = cyc;
      end
      if (ok_o)   n_ok++;
      if (fail_o) n_fl++;
      if (disc_o) n_dc++;
   end

   task automatic chk(input string req, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_starts(input int n);
      int guard = 0;
      while (n_start < n && guard < 200) begin
         @(negedge clk);
         guard++;
      end
   endtask

   task automatic req_msg(input logic rev3, input logic [2:0] id);
      msg_rev3_i = rev3; msg_id_i = id;
      msg_req_i = 1; @(negedge clk); msg_req_i = 0;
   endtask

   task automatic p_ok();   phy_ok_i = 1;   @(negedge clk); phy_ok_i = 0;   endtask
   task automatic p_fail(); phy_fail_i = 1; @(negedge clk); phy_fail_i = 0; endtask
   task automatic p_disc(); phy_disc_i = 1; @(negedge clk); phy_disc_i = 0; endtask
   task automatic p_rx();   rx_msg_i = 1;   @(negedge clk); rx_msg_i = 0;   endtask
   task automatic p_ack(input logic [2:0] id);
      rx_ack_id_i = id; rx_ack_i = 1; @(negedge clk); rx_ack_i = 0;
   endtask

   task automatic t_reset();
      chk("R13 start after reset", int'(start_o), 0);
      chk("R13 status after reset", int'({ok_o, fail_o, disc_o}), 0);
   endtask

   task automatic t_basic();
      int b = n_start, bo = n_ok;
      req_msg(1'b1, 3'd5);
      wait_starts(b + 1);
      chk("R13 message source code", last_src, 1);
      p_ok();
      p_ack(3'd3);
      idle(3);
      chk("R6 wrong-ID acknowledge ignored", n_ok - bo, 0);
      p_ack(3'd5);
      chk("R6 ok one cycle after matching ack", int'(ok_o), 1);
      @(negedge clk);
      chk("R13 ok is one cycle", int'(ok_o), 0);
      chk("R6 single success", n_ok - bo, 1);
   endtask

   task automatic t_timeout();
      int b = n_start, bf = n_fl, c0;
      req_msg(1'b1, 3'd2);
      wait_starts(b + 1);
      for (int k = 0; k < 3; k++) begin
         p_ok();
         c0 = cyc;
         if (k < 2) begin
            wait_starts(b + k + 2);
            if (k == 0) chk("R7 wait length before retry", last_start_cyc - c0, TOUT);
         end
      end
      idle(TOUT + 2);
      chk("R8 rev3 timeout starts", n_start - b, 3);
      chk("R7 fail after last timeout", n_fl - bf, 1);
   endtask

   task automatic t_retry();
      int b = n_start, bf = n_fl, bd = n_dc;
      req_msg(1'b0, 3'd6);
      for (int k = 0; k < 4; k++) begin
         wait_starts(b + k + 1);
         p_fail();
      end
      idle(3);
      chk("R8 rev2 starts on phy fail", n_start - b, 4);
      chk("R8 fail at limit", n_fl - bf, 1);
      chk("R8 no discard on fail path", n_dc - bd, 0);
      b = n_start; bf = n_fl; bd = n_dc;
      req_msg(1'b1, 3'd6);
      for (int k = 0; k < 3; k++) begin
         wait_starts(b + k + 1);
         p_disc();
      end
      idle(3);
      chk("R12 count restarts, rev3 starts", n_start - b, 3);
      chk("R8 discard at limit", n_dc - bd, 1);
      chk("R8 no fail on discard path", n_fl - bf, 0);
   endtask

   task automatic t_ack_first();
      int b = n_start, bo = n_ok, bf = n_fl, bd = n_dc;
      msg_rev3_i = 1; msg_id_i = 3'd1;
      ack_req_i = 1; msg_req_i = 1; @(negedge clk); ack_req_i = 0; msg_req_i = 0;
      wait_starts(b + 1);
      chk("R3 acknowledge goes first", last_src, 0);
      idle(4);
      chk("R3 message held during acknowledge", n_start - b, 1);
      p_fail();
      wait_starts(b + 2);
      chk("R3 message after acknowledge", last_src, 1);
      chk("R11 no status from acknowledge", (n_ok - bo) + (n_fl - bf) + (n_dc - bd), 0);
      p_ok();
      p_ack(3'd1);
      idle(2);
      chk("R6 message acknowledged", n_ok - bo, 1);
   endtask

   task automatic t_rx_block();
      int b = n_start, bd = n_dc, bo = n_ok;
      rx_busy_i = 1;
      req_msg(1'b1, 3'd4);
      idle(5);
      chk("R5 no start while receiving", n_start - b, 0);
      p_rx();
      chk("R4 discard pulse for pending message", int'(disc_o), 1);
      rx_busy_i = 0;
      idle(5);
      chk("R4 dropped message never starts", n_start - b, 0);
      chk("R4 one discard", n_dc - bd, 1);
      rx_busy_i = 1;
      req_msg(1'b1, 3'd4);
      idle(4);
      chk("R5 held while busy", n_start - b, 0);
      rx_busy_i = 0;
      wait_starts(b + 1);
      chk("R5 starts after busy falls", last_src, 1);
      p_ok();
      p_ack(3'd4);
      idle(2);
      chk("R5 message completes", n_ok - bo, 1);
   endtask

   task automatic t_rx_during();
      int b = n_start, bd = n_dc, bf = n_fl;
      req_msg(1'b0, 3'd7);
      wait_starts(b + 1);
      p_rx();
      p_fail();
      idle(3);
      chk("R9 discard after reception", n_dc - bd, 1);
      chk("R9 no retransmission", n_start - b, 1);
      chk("R9 no fail", n_fl - bf, 0);
   endtask

   task automatic t_rx_wait();
      int b = n_start, bd = n_dc, bo = n_ok;
      req_msg(1'b1, 3'd0);
      wait_starts(b + 1);
      p_ok();
      p_rx();
      idle(2);
      chk("R10 discard while waiting", n_dc - bd, 1);
      chk("R10 no success", n_ok - bo, 0);
      idle(TOUT + 5);
      chk("R10 no retry after discard", n_start - b, 1);
   endtask

   task automatic t_hard_reset();
      int b = n_start, bf = n_fl, bd = n_dc, bo = n_ok;
      req_msg(1'b1, 3'd4);
      wait_starts(b + 1);
      ack_req_i = 1; @(negedge clk); ack_req_i = 0;
      hr_req_i = 1; @(negedge clk); hr_req_i = 0;
      chk("R1 hard reset start next cycle", int'(start_o), 1);
      chk("R1 hard reset source code", int'(start_src_o), 2);
      req_msg(1'b1, 3'd4);
      p_fail();
      hr_done_i = 1; @(negedge clk); hr_done_i = 0;
      idle(20);
      chk("R2 pending requests cleared", n_start - b, 2);
      chk("R2 no status from hard reset", (n_fl - bf) + (n_dc - bd) + (n_ok - bo), 0);
      b = n_start;
      hr_req_i = 1; @(negedge clk); hr_req_i = 0;
      chk("R1 hard reset from idle", last_src, 2);
      hr_fail_i = 1; @(negedge clk); hr_fail_i = 0;
      idle(2);
      req_msg(1'b1, 3'd2);
      wait_starts(b + 2);
      chk("R2 normal service after hard reset fail", last_src, 1);
      p_ok();
      p_ack(3'd2);
      idle(2);
      chk("R2 message succeeds after hard reset", n_ok - bo, 1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);
      t_reset();
      t_basic();
      idle(2);
      t_timeout();
      idle(2);
      t_retry();
      idle(2);
      t_ack_first();
      idle(2);
      t_rx_block();
      idle(2);
      t_rx_during();
      idle(2);
      t_rx_wait();
      idle(2);
      t_hard_reset();
      idle(2);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule